// File: doc/BRIEF.md
# Streaming Configuration Byte Packer

This block sits between a source of configuration-image bytes and a device that takes its image over a valid/ready streaming bus. Bytes arrive one per cycle under their own valid/ready handshake. The block gathers them into words of one, two or four byte lanes, chosen by a static bus-width input. It hands each finished word to the device only when the device's flow control allows.

Lanes fill little-endian: the first byte of a word lands in the lowest lane. An end-of-image marker on the final byte sends out a partly filled word with zeroed upper lanes. The block never offers a word before it has seen the device's ready high at least once. When the device raises its configuration-done flag, the block stops offering words and swallows any further bytes. A word counter records every accepted transfer. The clock is assumed to run without pause.

Top module: `cfg_stream_packer`

## Requirements
- R1: With `mode` = 2 (or 3), four accepted bytes b0..b3 form one 32-bit word {b3,b2,b1,b0}. The bytes 02,1B,EE,01 yield 0x01EE1B02.
- R2: With `mode` = 1, each pair b0,b1 forms {16'h0,b1,b0} on `out_data`. The bytes 02,1B,EE,01 yield 0x1B02 and then 0x01EE.
- R3: With `mode` = 0, every accepted byte becomes its own word in `out_data[7:0]`, with the upper bits zero.
- R4: `out_valid` stays low until `out_ready` has been sampled high at a clock edge since reset.
- R5: While `out_valid` is high and `out_ready` is low, no word moves. In the next cycle `out_valid` is still high and `out_data` is unchanged, unless `cfg_done` was high.
- R6: While a complete word waits and is not being taken in the current cycle, `in_ready` is low. A byte can enter in the same cycle that a waiting word is accepted.
- R7: After `cfg_done` is sampled high, `done_o` goes high and stays high. `out_valid` stays low, `in_ready` stays high, incoming bytes are discarded and `word_count` no longer changes. A handshake in the same cycle as that `cfg_done` still completes and is counted.
- R8: A byte taken with `in_last` high closes the current word. Its unfilled upper lanes read zero.
- R9: `word_count` rises by exactly one for each cycle in which `out_valid` and `out_ready` are both high, and holds otherwise.
- R10: A synchronous `rst` clears `word_count`, `done_o`, the record of ready having been seen, any waiting word and the lane index. After reset, the next byte goes to lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Bus width: 0 = 8 bit, 1 = 16 bit, 2/3 = 32 bit; held static |
| in_byte | input | 8 | Image byte |
| in_valid | input | 1 | Image byte present |
| in_last | input | 1 | Marks the final byte of the image |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_data | output | 32 | Packed word to the device |
| out_valid | output | 1 | A complete word is offered |
| out_ready | input | 1 | Device flow control |
| cfg_done | input | 1 | Device reports configuration finished |
| done_o | output | 1 | Sticky: configuration-done seen |
| word_count | output | 32 | Number of words transferred |

## Verification
The arrival of `cfg_done` and the acceptance of a word can fall in the same cycle. The bench provokes this in 8-bit mode: it holds a word pending with ready already seen, then drives `cfg_done` and `out_ready` high together. It then expects the word to be compared and counted, `done_o` to be high on the next cycle, and the count to stay frozen while further bytes are swallowed. Refilling a lane in the same cycle that the waiting word leaves also comes up. It is exercised by random ready patterns, and every transfer is judged against a byte-level model.

// File: rtl/cfg_pack_pkg.sv
package cfg_pack_pkg;
   typedef enum logic [1:0] {
      BUS_X8   = 2'd0,
      BUS_X16  = 2'd1,
      BUS_X32  = 2'd2,
      BUS_WIDE = 2'd3
   } bus_mode_e;
endpackage

// File: rtl/cfg_pack_lanes.sv
// Byte lane assembly: writes accepted bytes into successive lanes.
module cfg_pack_lanes
   import cfg_pack_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int WORD_W = LANE_W * LANES
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mode,
   input  logic              take,
   input  logic              last_in,
   input  logic [LANE_W-1:0] byte_in,
   input  logic              flush,
   output logic              complete,
   output logic [WORD_W-1:0] word_o
);
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  top_idx;
   logic [LANE_W-1:0] lane_q [LANES];

   always_comb begin
      case (bus_mode_e'(mode))
         BUS_X8:  top_idx = '0;
         BUS_X16: top_idx = IDX_W'(1);
         default: top_idx = IDX_W'(LANES - 1);
      endcase
   end

   assign complete = take & ((idx_q == top_idx) | last_in);

   always_ff @(posedge clk) begin
      if (rst)
         idx_q <= '0;
      else if (take)
         idx_q <= complete ? '0 : idx_q + IDX_W'(1);
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst)
            lane_q[g] <= '0;
         else if (take && idx_q == IDX_W'(g))
            lane_q[g] <= byte_in;
         else if (flush)
            lane_q[g] <= '0;
      end
      assign word_o[g*LANE_W +: LANE_W] = lane_q[g];
   end
endmodule

// File: rtl/cfg_pack_ctrl.sv
// Handshake control: full flag, ready-seen gate, done latch.
module cfg_pack_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic complete,
   input  logic out_ready,
   input  logic cfg_done,
   output logic in_ready,
   output logic out_valid,
   output logic take,
   output logic fire,
   output logic done_o
);
   logic full_q, seen_q, done_q;

   assign out_valid = full_q & seen_q & ~done_q;
   assign fire      = out_valid & out_ready;
   assign in_ready  = done_q | ~full_q | fire;
   assign take      = in_valid & in_ready & ~done_q;
   assign done_o    = done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
         seen_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (complete)
            full_q <= 1'b1;
         else if (fire)
            full_q <= 1'b0;
         if (out_ready)
            seen_q <= 1'b1;
         if (cfg_done)
            done_q <= 1'b1;
      end
   end
endmodule

// File: rtl/cfg_pack_counter.sv
module cfg_pack_counter #(
   parameter int CNT_W = 32
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (inc)
         count <= count + CNT_W'(1);
   end
endmodule

// File: rtl/cfg_stream_packer.sv
module cfg_stream_packer #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   parameter int CNT_W  = 32,
   localparam int DATA_W = LANE_W * LANES
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mode,
   input  logic [LANE_W-1:0] in_byte,
   input  logic              in_valid,
   input  logic              in_last,
   output logic              in_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   input  logic              out_ready,
   input  logic              cfg_done,
   output logic              done_o,
   output logic [CNT_W-1:0]  word_count
);
   if (LANES < 4) begin : g_bad_lanes
      $error("cfg_stream_packer: LANES must be at least 4");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("cfg_stream_packer: LANE_W must be positive");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("cfg_stream_packer: CNT_W must be positive");
   end

   logic take, fire, complete;

   cfg_pack_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .complete  (complete),
      .out_ready (out_ready),
      .cfg_done  (cfg_done),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .take      (take),
      .fire      (fire),
      .done_o    (done_o)
   );

   cfg_pack_lanes #(.LANE_W(LANE_W), .LANES(LANES)) u_lanes (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode),
      .take     (take),
      .last_in  (in_last),
      .byte_in  (in_byte),
      .flush    (fire),
      .complete (complete),
      .word_o   (out_data)
   );

   cfg_pack_counter #(.CNT_W(CNT_W)) u_count (
      .clk   (clk),
      .rst   (rst),
      .inc   (fire),
      .count (word_count)
   );
endmodule

// File: rtl/cfg_pack_checker.sv
module cfg_pack_checker #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
)(
   input logic              clk,
   input logic              rst,
   input logic              in_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_valid,
   input logic              out_ready,
   input logic              cfg_done,
   input logic              done_o,
   input logic [CNT_W-1:0]  word_count
);
   logic chk_seen;

   always_ff @(posedge clk) begin
      if (rst)
         chk_seen <= 1'b0;
      else if (out_ready)
         chk_seen <= 1'b1;
   end

   p_valid_needs_ready_r4: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> chk_seen);

   p_hold_stall_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready && !cfg_done) |=> (out_valid && $stable(out_data)));

   p_block_input_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

   p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!out_valid && in_ready));

   p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      done_o |=> done_o);

   p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready) |=> (word_count == $past(word_count) + CNT_W'(1)));

   p_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !(out_valid && out_ready) |=> $stable(word_count));

   p_reset_clear_r10: assert property (@(posedge clk)
      rst |=> (word_count == '0 && !done_o && !out_valid));
endmodule

bind cfg_stream_packer cfg_pack_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_ready   (in_ready),
   .out_data   (out_data),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .cfg_done   (cfg_done),
   .done_o     (done_o),
   .word_count (word_count)
);

// File: tb/test_cfg_stream_packer.sv
`timescale 1ns/1ps
module test_cfg_stream_packer;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  mode = 2'd2;
   logic [7:0]  in_byte = '0;
   logic        in_valid = 1'b0;
   logic        in_last = 1'b0;
   logic        in_ready;
   logic [31:0] out_data;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic        cfg_done = 1'b0;
   logic        done_o;
   logic [31:0] word_count;

   always #10 clk = ~clk;

   cfg_stream_packer i_cfg_stream_packer (
      .clk(clk), .rst(rst), .mode(mode), .in_byte(in_byte), .in_valid(in_valid),
      .in_last(in_last), .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
      .out_ready(out_ready), .cfg_done(cfg_done), .done_o(done_o), .word_count(word_count)
   );

   int checks = 0;
   int fails  = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic [31:0] fired_log [$];
   logic [31:0] acc_w = '0;
   int          ex_idx = 0;
   bit          seen = 0;
   bit          prev_stall = 0;
   logic [31:0] prev_data = '0;
   int          fired_total = 0;
   logic        cd_drive = 1'b0;

   function automatic int lanes_of(logic [1:0] m);
      case (m)
         2'd0: return 1;
         2'd1: return 2;
         default: return 4;
      endcase
   endfunction

   function automatic string mode_tag(logic [1:0] m);
      case (m)
         2'd0: return "R3";
         2'd1: return "R2";
         default: return "R1";
      endcase
   endfunction

   task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", what, act, expv);
      end
   endtask

   task automatic model_take(input logic [7:0] b, input logic il);
      acc_w[ex_idx*8 +: 8] = b;
      if (ex_idx == lanes_of(mode) - 1 || il) begin
         exp_q.push_back(acc_w);
         tag_q.push_back((il && ex_idx != lanes_of(mode) - 1) ? "R8" : mode_tag(mode));
         acc_w = '0;
         ex_idx = 0;
      end else begin
         ex_idx++;
      end
   endtask

   task automatic step(input logic iv, input logic [7:0] ib, input logic il,
                       input logic ordy, output bit acc);
      @(negedge clk);
      in_valid = iv; in_byte = ib; in_last = il; out_ready = ordy; cfg_done = cd_drive;
      #1;
      acc = 0;
      if (prev_stall)
         check(out_valid === 1'b1 && out_data === prev_data, "R5 stalled word held", out_data, prev_data);
      if (!seen)
         check(out_valid === 1'b0, "R4 valid before ready seen", {31'd0, out_valid}, 32'd0);
      if (exp_q.size() > 0 && !done_o && !(out_valid && out_ready))
         check(in_ready === 1'b0, "R6 input blocked while word waits", {31'd0, in_ready}, 32'd0);
      if (done_o)
         check(out_valid === 1'b0 && in_ready === 1'b1, "R7 quiet after done",
               {30'd0, out_valid, in_ready}, 32'd1);
      if (out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected transfer", out_data, 32'd0);
         end else begin
            logic [31:0] e = exp_q.pop_front();
            string t = tag_q.pop_front();
            check(out_data === e, {t, " packed word"}, out_data, e);
         end
         fired_log.push_back(out_data);
         fired_total++;
      end
      if (iv && in_ready) begin
         acc = 1;
         if (!done_o) model_take(ib, il);
      end
      if (ordy) seen = 1;
      prev_stall = out_valid && !out_ready && !cfg_done;
      prev_data = out_data;
   endtask

   task automatic do_reset(input logic [1:0] m);
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; cd_drive = 1'b0; cfg_done = 1'b0; mode = m;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      exp_q.delete(); tag_q.delete(); fired_log.delete();
      acc_w = '0; ex_idx = 0; seen = 0; prev_stall = 0; fired_total = 0;
      #1;
      check(out_valid === 1'b0 && in_ready === 1'b1 && done_o === 1'b0 && word_count === 32'd0,
            "R10 reset state", word_count, 32'd0);
   endtask

   task automatic send_directed(input logic [7:0] b, input logic il, input logic ordy);
      bit acc = 0;
      int guard = 0;
      while (!acc && guard < 50) begin
         step(1'b1, b, il, ordy, acc);
         guard++;
      end
   endtask

   task automatic drain(input int n);
      bit acc;
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b1, acc);
   endtask

   task automatic stream(input int nbytes, input bit end_last, input int rdy_pct);
      int sent = 0;
      int guard = 0;
      logic [7:0] cur = 8'($urandom);
      bit acc;
      while ((sent < nbytes || exp_q.size() > 0) && guard < 5000) begin
         logic iv = (sent < nbytes) && ($urandom % 4 != 0);
         logic il = end_last && (sent == nbytes - 1);
         logic rd = ($urandom % 100) < rdy_pct;
         step(iv, cur, il, rd, acc);
         if (acc) begin
            sent++;
            cur = 8'($urandom);
         end
         guard++;
      end
      check(exp_q.size() == 0, "R9 all words delivered", exp_q.size(), 32'd0);
      drain(1);
      check(word_count === 32'(fired_total), "R9 word count", word_count, fired_total);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      bit acc;
      void'($urandom(32'd20517));

      // R10: stray byte before reset must not shift the next word
      do_reset(2'd2);
      step(1'b1, 8'hAA, 1'b0, 1'b0, acc);
      do_reset(2'd2);

      // R1 directed: ready held low, valid must wait (R4), input blocks (R6)
      send_directed(8'h02, 1'b0, 1'b0);
      send_directed(8'h1B, 1'b0, 1'b0);
      send_directed(8'hEE, 1'b0, 1'b0);
      send_directed(8'h01, 1'b0, 1'b0);
      step(1'b1, 8'h55, 1'b0, 1'b0, acc);
      step(1'b1, 8'h55, 1'b0, 1'b0, acc);
      check(out_valid === 1'b0, "R4 word full but ready never seen", {31'd0, out_valid}, 32'd0);
      drain(3);
      check(fired_log.size() == 1 && fired_log[0] === 32'h01EE1B02, "R1 directed word",
            fired_log.size() > 0 ? fired_log[0] : 32'hx, 32'h01EE1B02);
      check(word_count === 32'd1, "R9 one word counted", word_count, 32'd1);

      // R2 directed
      do_reset(2'd1);
      send_directed(8'h02, 1'b0, 1'b1);
      send_directed(8'h1B, 1'b0, 1'b0);
      send_directed(8'hEE, 1'b0, 1'b1);
      send_directed(8'h01, 1'b0, 1'b1);
      drain(3);
      check(fired_log.size() == 2 && fired_log[0] === 32'h1B02 && fired_log[1] === 32'h01EE,
            "R2 directed words", fired_log.size() > 1 ? fired_log[1] : 32'hx, 32'h01EE);

      // R8 directed: three bytes then end of image in 32-bit mode
      do_reset(2'd2);
      send_directed(8'h11, 1'b0, 1'b1);
      send_directed(8'h22, 1'b0, 1'b1);
      send_directed(8'h33, 1'b1, 1'b1);
      drain(3);
      check(fired_log.size() == 1 && fired_log[0] === 32'h00332211, "R8 flushed partial word",
            fired_log.size() > 0 ? fired_log[0] : 32'hx, 32'h00332211);

      // Random streams in each mode
      do_reset(2'd0); stream(60, 1'b0, 70);
      do_reset(2'd1); stream(81, 1'b1, 50);
      do_reset(2'd2); stream(120, 1'b0, 90);
      do_reset(2'd2); stream(103, 1'b1, 30);
      do_reset(2'd3); stream(64, 1'b0, 100);
      do_reset(2'd1); stream(90, 1'b0, 100);

      // R7: done coinciding with a handshake in 8-bit mode
      do_reset(2'd0);
      send_directed(8'h5A, 1'b0, 1'b1);
      cd_drive = 1'b1;
      step(1'b0, 8'h00, 1'b0, 1'b1, acc);
      cd_drive = 1'b0;
      step(1'b0, 8'h00, 1'b0, 1'b1, acc);
      check(done_o === 1'b1, "R7 done latched", {31'd0, done_o}, 32'd1);
      check(word_count === 32'd1 && fired_log.size() == 1 && fired_log[0] === 32'h5A,
            "R7 same-cycle transfer counted", word_count, 32'd1);
      for (int i = 0; i < 6; i++) begin
         step(1'b1, 8'(i + 1), 1'b0, 1'b1, acc);
         check(acc == 1, "R7 byte swallowed after done", {31'd0, acc}, 32'd1);
      end
      check(word_count === 32'd1 && done_o === 1'b1, "R7 count frozen after done", word_count, 32'd1);

      // R7: pending word discarded when done arrives with ready low
      do_reset(2'd1);
      send_directed(8'h01, 1'b0, 1'b0);
      send_directed(8'h02, 1'b0, 1'b0);
      cd_drive = 1'b1;
      step(1'b0, 8'h00, 1'b0, 1'b0, acc);
      cd_drive = 1'b0;
      exp_q.delete(); tag_q.delete();
      step(1'b1, 8'h03, 1'b0, 1'b1, acc);
      drain(4);
      check(word_count === 32'd0 && done_o === 1'b1, "R7 nothing sent after done", word_count, 32'd0);

      // R10: reset clears done
      do_reset(2'd2);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule